// File: doc/BRIEF.md
# Slave DMA Request Handshake Controller

This block is the device-side end of a slave DMA link. It belongs to a peripheral whose local buffer memory is filled or drained by a system DMA controller. Software loads a start address, a word count, a burst size, the data width and the active levels of the request and acknowledge lines. The block then raises its request line. It counts each acknowledged read or write strobe as one data word, steps the buffer address for every word, and drops the request at the end of each burst.

After a burst, the request comes back once the acknowledge has gone away, as long as words remain. On the last word the request is dropped and stays low until software loads a new program. No end-of-transfer pin exists. Completion is reported only through an interrupt flag, which can be enabled and is cleared by writing 1 to it. A program with a misaligned start address or a zero count is refused, and a sticky error flag records the refusal. Strobes seen while the acknowledge is inactive belong to ordinary register or memory accesses, so they leave the transfer state alone.

Top module: `dma_slave_req`

## Requirements
- R1: After reset the request output is low (active-high default), `busy`, `irq` and `prog_err` are 0.
- R2: A valid program (count of at least 1, aligned start) sets `busy` and asserts the request in the cycle after `prog_we`, with `buf_addr` equal to the start address.
- R3: `prog_burst` selects the words per burst: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16. The request is deasserted in the cycle after the strobe that ends a burst.
- R4: After a burst, the request stays deasserted while the acknowledge is active. It is asserted again in the cycle after the acknowledge is sampled inactive, if words remain.
- R5: The strobe that carries the last word deasserts the request and clears `busy`. Both stay that way until the next `prog_we`.
- R6: `prog_req_hi`=1 makes the request active-high and 0 makes it active-low. `prog_ack_hi` sets the acknowledge level in the same way.
- R7: Every counted word advances `buf_addr` by 2 when `prog_wide`=0 (16-bit) or by 4 when `prog_wide`=1 (32-bit), and lowers `words_left` by 1.
- R8: A read or write strobe while the acknowledge is inactive does not drive `buf_en`, and it leaves `buf_addr` and `words_left` unchanged.
- R9: A start address with bit 0 set in 16-bit mode, or with bits 1:0 nonzero in 32-bit mode, sets `prog_err` and leaves `busy` at 0. `prog_err` is cleared only by reset.
- R10: A count of zero is refused: `busy` stays 0 and `prog_err` is set.
- R11: `irq` is set by the last word only when `prog_irq_en` was 1, and is cleared by a pulse on `irq_clr`. A set in the same cycle wins over the clear.
- R12: An acknowledged strobe counts as a word while `busy` is 1, even while the request is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prog_we | input | 1 | Load the program fields below |
| prog_addr | input | AW | Start byte address |
| prog_count | input | CW | Number of data words |
| prog_burst | input | 2 | Burst size code |
| prog_wide | input | 1 | 1 = 32-bit words, 0 = 16-bit |
| prog_req_hi | input | 1 | Request active level |
| prog_ack_hi | input | 1 | Acknowledge active level |
| prog_irq_en | input | 1 | Enable completion interrupt |
| irq_clr | input | 1 | Write-1 clear of `irq` |
| ack_in | input | 1 | Acknowledge from the system DMA |
| rd_stb | input | 1 | Read strobe, one cycle per word |
| wr_stb | input | 1 | Write strobe, one cycle per word |
| req_out | output | 1 | Request to the system DMA |
| buf_addr | output | AW | Current buffer byte address |
| buf_en | output | 1 | Buffer access for this word |
| buf_wr | output | 1 | Buffer access is a write |
| words_left | output | CW | Words still to move |
| busy | output | 1 | Transfer programmed and not finished |
| prog_err | output | 1 | Sticky refused-program flag |
| irq | output | 1 | Completion interrupt flag |

## Verification
All results except `buf_en` and `buf_wr` come from registers. They are due exactly one clock after the edge that samples the stimulus: a program, a strobe or an acknowledge change. The bench drives each input on a falling edge and reads the effect on the next falling edge, so every check lands one cycle after its cause. `buf_en` and `buf_wr` follow the strobe in the same cycle, so they are read one nanosecond after the strobe is driven, before any edge. The check that the request stays low while the acknowledge is held repeats that read over further idle cycles.

// File: rtl/dma_slave_req.sv
module dma_slave_req #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic [CW-1:0] prog_count,
  input  logic [1:0]    prog_burst,
  input  logic          prog_wide,
  input  logic          prog_req_hi,
  input  logic          prog_ack_hi,
  input  logic          prog_irq_en,
  input  logic          irq_clr,
  input  logic          ack_in,
  input  logic          rd_stb,
  input  logic          wr_stb,
  output logic          req_out,
  output logic [AW-1:0] buf_addr,
  output logic          buf_en,
  output logic          buf_wr,
  output logic [CW-1:0] words_left,
  output logic          busy,
  output logic          prog_err,
  output logic          irq
);
  localparam int BW = 4;

  logic          wide_q, req_hi_q, ack_hi_q, irq_en_q, hold_q;
  logic [1:0]    burst_q;
  logic [BW-1:0] beat_q, beat_lim;
  logic          ack_on, xfer, last_beat, final_word, misalign, prog_ok, req_on, irq_set;

  assign ack_on     = ack_hi_q ? ack_in : ~ack_in;
  assign xfer       = busy & ack_on & (rd_stb | wr_stb);
  assign beat_lim   = {burst_q == 2'd3, burst_q[1], burst_q != 2'd0, burst_q != 2'd0};
  assign last_beat  = beat_q == beat_lim;
  assign final_word = words_left == CW'(1);
  assign misalign   = prog_wide ? |prog_addr[1:0] : prog_addr[0];
  assign prog_ok    = ~misalign & |prog_count;
  assign req_on     = busy & ~hold_q;
  assign req_out    = req_hi_q ? req_on : ~req_on;
  assign buf_en     = xfer;
  assign buf_wr     = xfer & wr_stb;
  assign irq_set    = xfer & final_word & irq_en_q & ~prog_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      prog_err   <= 1'b0;
      hold_q     <= 1'b0;
      beat_q     <= '0;
      buf_addr   <= '0;
      words_left <= '0;
      burst_q    <= 2'd0;
      wide_q     <= 1'b0;
      req_hi_q   <= 1'b1;
      ack_hi_q   <= 1'b1;
      irq_en_q   <= 1'b0;
    end else if (prog_we) begin
      buf_addr   <= prog_addr;
      words_left <= prog_count;
      burst_q    <= prog_burst;
      wide_q     <= prog_wide;
      req_hi_q   <= prog_req_hi;
      ack_hi_q   <= prog_ack_hi;
      irq_en_q   <= prog_irq_en;
      busy       <= prog_ok;
      hold_q     <= 1'b0;
      beat_q     <= '0;
      if (!prog_ok) prog_err <= 1'b1;
    end else if (xfer) begin
      buf_addr   <= buf_addr + (wide_q ? AW'(4) : AW'(2));
      words_left <= words_left - CW'(1);
      if (final_word) begin
        busy   <= 1'b0;
        beat_q <= '0;
      end else if (last_beat) begin
        hold_q <= 1'b1;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + BW'(1);
      end
    end else if (hold_q && !ack_on) begin
      hold_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  p_prog_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we && misalign |=> !busy && prog_err);

  p_burst_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && last_beat && !prog_we |=> !req_on);

  p_done_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !prog_we |=> !busy);

  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer && !prog_we |=> $stable(buf_addr) && $stable(words_left));

  p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q && !irq && !prog_we |=> !irq);

  p_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && hold_q && !ack_on && !prog_we |=> req_on);
endmodule

// File: tb/dma_slave_req_tb.sv
module dma_slave_req_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [15:0] prog_addr = '0;
  logic [15:0] prog_count = '0;
  logic [1:0]  prog_burst = '0;
  logic        prog_wide = 1'b0, prog_req_hi = 1'b1, prog_ack_hi = 1'b1, prog_irq_en = 1'b0;
  logic        irq_clr = 1'b0, ack_in = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic        req_out, buf_en, buf_wr, busy, prog_err, irq;
  logic [15:0] buf_addr, words_left;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dma_slave_req u_dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_count(prog_count), .prog_burst(prog_burst), .prog_wide(prog_wide),
    .prog_req_hi(prog_req_hi), .prog_ack_hi(prog_ack_hi), .prog_irq_en(prog_irq_en),
    .irq_clr(irq_clr), .ack_in(ack_in), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .req_out(req_out), .buf_addr(buf_addr), .buf_en(buf_en), .buf_wr(buf_wr),
    .words_left(words_left), .busy(busy), .prog_err(prog_err), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ack_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic program_it(input logic [15:0] a, input logic [15:0] n, input logic [1:0] b,
                            input logic w, input logic rh, input logic ah, input logic ie);
    prog_addr = a; prog_count = n; prog_burst = b; prog_wide = w;
    prog_req_hi = rh; prog_ack_hi = ah; prog_irq_en = ie; prog_we = 1'b1;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic pulse(input logic wr);
    if (wr) wr_stb = 1'b1; else rd_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 req_out", req_out, 0);
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 prog_err", prog_err, 0);
  endtask

  task automatic t_basic();
    program_it(16'h0100, 16'd6, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R2 req asserted", req_out, 1);
    chk("R2 start addr", buf_addr, 16'h0100);
    chk("R2 busy", busy, 1);
    ack_in = 1'b1;
    for (int i = 0; i < 3; i++) pulse(1'b1);
    chk("R3 req held mid burst", req_out, 1);
    wr_stb = 1'b1; #1;
    chk("R7 buf_wr on acked write", buf_wr, 1);
    @(negedge clk); wr_stb = 1'b0;
    chk("R3 req drop after 4 words", req_out, 0);
    chk("R7 addr step 2", buf_addr, 16'h0108);
    chk("R7 words_left", words_left, 2);
    @(negedge clk);
    chk("R4 req low while ack held", req_out, 0);
    ack_in = 1'b0;
    @(negedge clk);
    chk("R4 req back after ack off", req_out, 1);
    rd_stb = 1'b1; #1;
    chk("R8 no buf_en without ack", buf_en, 0);
    @(negedge clk); rd_stb = 1'b0;
    chk("R8 addr unchanged", buf_addr, 16'h0108);
    chk("R8 count unchanged", words_left, 2);
    ack_in = 1'b1;
    pulse(1'b0);
    pulse(1'b0);
    chk("R5 req drop at end", req_out, 0);
    chk("R5 busy clear", busy, 0);
    chk("R11 irq set", irq, 1);
    ack_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 req stays low", req_out, 0);
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R11 irq cleared", irq, 0);
  endtask

  task automatic t_wide_pol();
    ack_in = 1'b1;
    program_it(16'h0040, 16'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6 active-low req asserted", req_out, 0);
    ack_in = 1'b0;
    pulse(1'b0);
    chk("R7 addr step 4", buf_addr, 16'h0044);
    chk("R6 active-low req deasserted", req_out, 1);
    ack_in = 1'b1;
    @(negedge clk);
    chk("R6 req back with ack high=inactive", req_out, 0);
    ack_in = 1'b0;
    pulse(1'b0);
    ack_in = 1'b1;
    @(negedge clk);
    ack_in = 1'b0;
    pulse(1'b1);
    chk("R7 final addr", buf_addr, 16'h004C);
    chk("R5 busy clear wide", busy, 0);
    chk("R11 irq disabled", irq, 0);
    ack_in = 1'b1;
  endtask

  task automatic t_zero();
    do_reset();
    program_it(16'h0010, 16'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R10 zero count not busy", busy, 0);
    chk("R10 zero count err", prog_err, 1);
    chk("R10 no request", req_out, 0);
  endtask

  task automatic t_align();
    do_reset();
    program_it(16'h0042, 16'd4, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R9 wide misalign err", prog_err, 1);
    chk("R9 wide misalign idle", busy, 0);
    do_reset();
    program_it(16'h0041, 16'd4, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 narrow misalign err", prog_err, 1);
    chk("R9 no request", req_out, 0);
    program_it(16'h0040, 16'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 aligned starts", busy, 1);
    chk("R9 err sticky", prog_err, 1);
  endtask

  task automatic t_noreq();
    do_reset();
    program_it(16'h0000, 16'd2, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1);
    ack_in = 1'b1;
    pulse(1'b1);
    chk("R12 req low after burst", req_out, 0);
    pulse(1'b1);
    chk("R12 word counted without req", words_left, 0);
    chk("R12 addr advanced", buf_addr, 16'h0008);
    chk("R12 irq", irq, 1);
  endtask

  task automatic t_long_bursts();
    do_reset();
    program_it(16'h0200, 16'd8, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0);
    ack_in = 1'b1;
    for (int i = 0; i < 7; i++) pulse(1'b0);
    chk("R3 req held through 7 of 8", req_out, 1);
    pulse(1'b0);
    chk("R3 req drop after 8", req_out, 0);
    chk("R5 done after 8", busy, 0);
    chk("R7 addr after 8", buf_addr, 16'h0220);
    ack_in = 1'b0;
    @(negedge clk);
    program_it(16'h0000, 16'd17, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    ack_in = 1'b1;
    for (int i = 0; i < 15; i++) pulse(1'b1);
    chk("R3 req held through 15 of 16", req_out, 1);
    pulse(1'b1);
    chk("R3 req drop after 16", req_out, 0);
    chk("R4 still busy", busy, 1);
    chk("R7 one word left", words_left, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_basic();
    t_wide_pol();
    t_zero();
    t_align();
    t_noreq();
    t_long_bursts();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule